// File: doc/BRIEF.md
# Addressed Two-Wire Bus Slave

This block lets local logic take part in a two-wire serial bus as a target with a 7-bit address. It watches the clock and data pads through synchronizers. It spots start, repeated start and stop conditions, and it shifts in the first byte of each transfer. It compares the upper seven bits of that byte with a programmable own address. When they match, it acknowledges without any help from local logic. The low bit of that byte picks the direction of the transfer.

In a write transfer, each received byte is stored in a holding register. The byte is stored and acknowledged only when nothing is waiting there and no overflow is pending. In a read transfer, bytes come from a transmit value that local logic presents when it releases the clock. After each byte the block raises an interrupt on the falling edge of the ninth clock. It can also hold the clock line low until local logic pulses the release strobe. Both pad outputs are active-low pull-down enables for open-drain pads.

Top module: `i2c_addr_slave`

## Requirements
- R1: SDA falling while SCL is high (start, also accepted mid-transfer as a repeated start) begins a new address byte. SDA rising while SCL is high (stop) returns the block to idle with both pad pull-downs released.
- R2: Bits 7:1 of the first byte after a start are compared with `own_addr_i`. On a mismatch the byte is not acknowledged, no interrupt is raised, and the block ignores the bus until the next start.
- R3: On a match, the block pulls SDA low through the ninth clock of the address byte, and `rw_o` takes bit 0 of that byte (1 means the master reads).
- R4: A received data byte is copied to `rx_data_o`, sets `buf_full_o` and is acknowledged only if `buf_full_o` and `ovf_o` were both clear when its eighth bit completed. Otherwise it is answered with a NACK, and `rx_data_o` keeps its old value.
- R5: `irq_o` is set after the falling edge of the ninth clock of every byte in an addressed transfer, except a sent byte that the master NACKs. It stays set until `irq_clr_i`.
- R6: With `stretch_en_i` = 1 the block holds SCL low after every byte of an addressed transfer. With `stretch_en_i` = 0 it holds SCL only before it has to send a byte. The hold ends one cycle after a `release_i` pulse.
- R7: Bytes move most significant bit first, in both directions.
- R8: A received byte that completes while `buf_full_o` is set raises `ovf_o`, which stays set until `ovf_clr_i`. A `rd_i` pulse clears `buf_full_o`.
- R9: In a read transfer, the `release_i` pulse that ends a hold loads `tx_data_i` and puts its first bit on SDA before SCL is freed.
- R10: When the master answers a sent byte with a NACK (SDA high on the ninth clock), the block releases SDA, raises no interrupt, and stays idle until the next start.
- R11: The block changes its own SDA pull-down only while SCL is low, and `sda_drive_n`/`scl_drive_n` at 0 pull the pad low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Clock pad level |
| sda_i | input | 1 | Data pad level |
| scl_drive_n | output | 1 | Clock pad pull-down enable, active low |
| sda_drive_n | output | 1 | Data pad pull-down enable, active low |
| own_addr_i | input | 7 | Own bus address |
| stretch_en_i | input | 1 | Hold the clock after every byte |
| tx_data_i | input | 8 | Byte to send, taken at release |
| release_i | input | 1 | Ends the clock hold (pulse) |
| rd_i | input | 1 | Marks the held byte as taken (pulse) |
| irq_clr_i | input | 1 | Clears the interrupt flag (pulse) |
| ovf_clr_i | input | 1 | Clears the overflow flag (pulse) |
| rx_data_o | output | 8 | Holding register for received data |
| buf_full_o | output | 1 | Holding register occupied |
| ovf_o | output | 1 | Byte arrived while the holding register was occupied |
| rw_o | output | 1 | Direction of the current transfer, 1 = master reads |
| irq_o | output | 1 | Byte-complete interrupt flag |

## Verification
A pad edge takes two synchronizer cycles and one compare cycle to reach the engine. The pad pull-down outputs therefore change in the third cycle after the edge, and `irq_o`, `buf_full_o`, `ovf_o` and `rx_data_o` change one cycle after that. The released clock line rises two cycles after a `release_i` pulse. The bench acts as a master with a quarter bit period of ten cycles. It samples the pads in the middle of the high phase and reads the local flags ten cycles after each falling edge, so every result has settled before it is read. In transmit the bench waits for the clock line to go high, so a held clock only slows the bench and never breaks a check.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_RX, ST_TX} slv_state_t;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync
  import i2c_slv_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o,
  output logic    scl_o
);
  localparam int CW = 2 * STAGES;

  logic [CW-1:0] chain_q;
  logic [1:0]    prev_q;
  logic [1:0]    cur;

  assign cur = chain_q[CW-1 -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 2'b11;
    end else begin
      chain_q <= {chain_q[CW-3:0], scl_i, sda_i};
      prev_q  <= cur;
    end
  end

  always_comb begin
    ev_o.scl_rise = cur[1] & ~prev_q[1];
    ev_o.scl_fall = ~cur[1] & prev_q[1];
    ev_o.start    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
    ev_o.stop     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
    ev_o.sda      = cur[0];
  end

  assign scl_o = cur[1];
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              stretch_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              release_i,
  input  logic              full_i,
  input  logic              ovf_i,
  output logic              sda_pull_o,
  output logic              scl_hold_o,
  output logic              rw_o,
  output logic [DATA_W-1:0] shreg_o,
  output logic              ev_load_o,
  output logic              ev_ovf_o,
  output logic              ev_irq_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);

  slv_state_t        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              pull_q, pull_n;
  logic              hold_q, hold_n;
  logic              relp_q, relp_n;
  logic              rw_q, rw_n;
  logic              mack_q, mack_n;
  logic              load_n, ovfe_n, irqe_n;
  logic              load_q, ovfe_q, irqe_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    pull_n  = pull_q;
    hold_n  = hold_q;
    relp_n  = 1'b0;
    rw_n    = rw_q;
    mack_n  = mack_q;
    load_n  = 1'b0;
    ovfe_n  = 1'b0;
    irqe_n  = 1'b0;
    if (ev.start) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      pull_n  = 1'b0;
      hold_n  = 1'b0;
    end else if (ev.stop) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      pull_n  = 1'b0;
      hold_n  = 1'b0;
    end else begin
      if (relp_q) hold_n = 1'b0;
      if (hold_q && release_i && !relp_q) begin
        relp_n = 1'b1;
        if (state_q == ST_TX) begin
          sh_n   = tx_data;
          pull_n = ~tx_data[DATA_W-1];
        end
      end
      if (state_q != ST_IDLE) begin
        if (ev.scl_rise) begin
          if (cnt_q < LAST_BIT) begin
            if (state_q != ST_TX) sh_n = {sh_q[DATA_W-2:0], ev.sda};
            cnt_n = cnt_q + 1'b1;
          end else if (cnt_q == LAST_BIT) begin
            mack_n = ev.sda;
            cnt_n  = ACK_BIT;
          end
        end else if (ev.scl_fall) begin
          if (cnt_q == LAST_BIT) begin
            unique case (state_q)
              ST_ADDR: begin
                if (sh_q[DATA_W-1:1] == own_addr) begin
                  pull_n = 1'b1;
                  rw_n   = sh_q[0];
                end else begin
                  state_n = ST_IDLE;
                  cnt_n   = '0;
                end
              end
              ST_RX: begin
                if (!full_i && !ovf_i) begin
                  pull_n = 1'b1;
                  load_n = 1'b1;
                end else begin
                  pull_n = 1'b0;
                  ovfe_n = full_i;
                end
              end
              default: pull_n = 1'b0;
            endcase
          end else if (cnt_q == ACK_BIT) begin
            cnt_n  = '0;
            pull_n = 1'b0;
            unique case (state_q)
              ST_ADDR: begin
                irqe_n  = 1'b1;
                state_n = rw_q ? ST_TX : ST_RX;
                hold_n  = rw_q | stretch_en;
              end
              ST_RX: begin
                irqe_n = 1'b1;
                hold_n = stretch_en;
              end
              default: begin
                if (!mack_q) begin
                  irqe_n = 1'b1;
                  hold_n = 1'b1;
                end else begin
                  state_n = ST_IDLE;
                end
              end
            endcase
          end else if (state_q == ST_TX && cnt_q != '0) begin
            sh_n   = {sh_q[DATA_W-2:0], 1'b0};
            pull_n = ~sh_q[DATA_W-2];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      pull_q  <= 1'b0;
      hold_q  <= 1'b0;
      relp_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b1;
      load_q  <= 1'b0;
      ovfe_q  <= 1'b0;
      irqe_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      pull_q  <= pull_n;
      hold_q  <= hold_n;
      relp_q  <= relp_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      load_q  <= load_n;
      ovfe_q  <= ovfe_n;
      irqe_q  <= irqe_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign scl_hold_o = hold_q;
  assign rw_o       = rw_q;
  assign shreg_o    = sh_q;
  assign ev_load_o  = load_q;
  assign ev_ovf_o   = ovfe_q;
  assign ev_irq_o   = irqe_q;
endmodule

// File: rtl/i2c_slv_local.sv
module i2c_slv_local #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic              ev_ovf,
  input  logic              ev_irq,
  input  logic [DATA_W-1:0] shreg,
  input  logic              rd_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] rx_q, rx_n;
  logic full_q, full_n, ovf_q, ovf_n, irq_q, irq_n;

  always_comb begin
    rx_n   = ev_load ? shreg : rx_q;
    full_n = ev_load ? 1'b1 : (rd_i ? 1'b0 : full_q);
    ovf_n  = ev_ovf ? 1'b1 : (ovf_clr_i ? 1'b0 : ovf_q);
    irq_n  = ev_irq ? 1'b1 : (irq_clr_i ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      rx_q   <= rx_n;
      full_q <= full_n;
      ovf_q  <= ovf_n;
      irq_q  <= irq_n;
    end
  end

  assign rx_data_o = rx_q;
  assign full_o    = full_q;
  assign ovf_o     = ovf_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_n,
  output logic              sda_drive_n,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              stretch_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              release_i,
  input  logic              rd_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              rw_o,
  output logic              irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  bus_ev_t           ev;
  logic              scl_s;
  logic              sda_pull, scl_hold;
  logic [DATA_W-1:0] shreg;
  logic              ev_load, ev_ovf, ev_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .ev_o(ev), .scl_o(scl_s)
  );

  i2c_slv_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_s_n), .ev(ev), .own_addr(own_addr_i),
    .stretch_en(stretch_en_i), .tx_data(tx_data_i), .release_i(release_i),
    .full_i(buf_full_o), .ovf_i(ovf_o), .sda_pull_o(sda_pull),
    .scl_hold_o(scl_hold), .rw_o(rw_o), .shreg_o(shreg),
    .ev_load_o(ev_load), .ev_ovf_o(ev_ovf), .ev_irq_o(ev_irq)
  );

  i2c_slv_local #(.DATA_W(DATA_W)) u_loc (
    .clk(clk), .rst_n(rst_s_n), .ev_load(ev_load), .ev_ovf(ev_ovf),
    .ev_irq(ev_irq), .shreg(shreg), .rd_i(rd_i), .irq_clr_i(irq_clr_i),
    .ovf_clr_i(ovf_clr_i), .rx_data_o(rx_data_o), .full_o(buf_full_o),
    .ovf_o(ovf_o), .irq_o(irq_o)
  );

  assign sda_drive_n = ~sda_pull;
  assign scl_drive_n = ~scl_hold;
endmodule

// File: rtl/i2c_slv_chk.sv
module i2c_slv_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_sync,
  input logic sda_drive_n,
  input logic scl_drive_n,
  input logic release_i,
  input logic buf_full_o,
  input logic ovf_o,
  input logic irq_o
);
  p_sda_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_n) |-> !scl_sync);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(buf_full_o));

  p_irq_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$past(scl_sync));

  p_hold_until_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_n) |-> $past(release_i, 2));

  p_full_set_only_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full_o) |-> !$past(ovf_o));
endmodule

bind i2c_addr_slave i2c_slv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sync(scl_s), .sda_drive_n(sda_drive_n),
  .scl_drive_n(scl_drive_n), .release_i(release_i), .buf_full_o(buf_full_o),
  .ovf_o(ovf_o), .irq_o(irq_o)
);

// File: tb/sim_i2c_addr_slave.sv
module sim_i2c_addr_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic m_scl, m_sda;
  logic scl_drive_n, sda_drive_n;
  logic [6:0] own_addr;
  logic stretch_en;
  logic [7:0] tx_data;
  logic release_s, rd_s, irq_clr_s, ovf_clr_s;
  logic [7:0] rx_data;
  logic buf_full, ovf, rw, irq;
  logic scl_ln, sda_ln;

  assign scl_ln = m_scl & scl_drive_n;
  assign sda_ln = m_sda & sda_drive_n;

  i2c_addr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_drive_n(scl_drive_n), .sda_drive_n(sda_drive_n),
    .own_addr_i(own_addr), .stretch_en_i(stretch_en), .tx_data_i(tx_data),
    .release_i(release_s), .rd_i(rd_s), .irq_clr_i(irq_clr_s),
    .ovf_clr_i(ovf_clr_s), .rx_data_o(rx_data), .buf_full_o(buf_full),
    .ovf_o(ovf), .rw_o(rw), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic auto_sw;
  int rq_rel = 0, rq_rd = 0, rq_oclr = 0;
  logic [7:0] got [256];
  int gn;
  logic [7:0] txq [64];
  int tn;

  // local-side model: serves interrupts automatically or on request
  initial begin
    int sn_rel, sn_rd, sn_oclr;
    sn_rel = 0; sn_rd = 0; sn_oclr = 0; gn = 0; tn = 0;
    release_s = 0; rd_s = 0; irq_clr_s = 0; ovf_clr_s = 0; tx_data = 8'h00;
    forever begin
      @(negedge clk);
      release_s = 0; rd_s = 0; irq_clr_s = 0; ovf_clr_s = 0;
      if (rq_rd != sn_rd) begin sn_rd = rq_rd; rd_s = 1; end
      if (rq_oclr != sn_oclr) begin sn_oclr = rq_oclr; ovf_clr_s = 1; end
      if (rq_rel != sn_rel) begin sn_rel = rq_rel; release_s = 1; irq_clr_s = 1; end
      else if (auto_sw && irq) begin
        if (!rw && buf_full) begin got[gn] = rx_data; gn++; rd_s = 1; end
        if (rw) begin tx_data = txq[tn]; tn++; end
        irq_clr_s = 1; release_s = 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    int k;
    k = 0;
    while (!scl_ln && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic mbit(input logic b, output logic s);
    m_sda = b; wq(Q);
    m_scl = 1; wait_high(); wq(Q);
    s = sda_ln; wq(Q);
    m_scl = 0; wq(Q);
  endtask

  task automatic mstart();
    m_sda = 1; wq(Q);
    m_scl = 1; wait_high(); wq(Q);
    m_sda = 0; wq(Q);
    m_scl = 0; wq(Q);
  endtask

  task automatic mstop();
    m_sda = 0; wq(Q);
    m_scl = 1; wait_high(); wq(Q);
    m_sda = 1; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) mbit(d[i], s);
    mbit(1'b1, ack);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin mbit(1'b1, s); d[i] = s; end
    mbit(mack, s);
  endtask

  function automatic logic exp_ack(input logic [6:0] a, input logic [6:0] own);
    return (a == own) ? 1'b0 : 1'b1;
  endfunction

  task automatic run_all();
    logic ack;
    logic [7:0] d;
    int g0, t0;
    logic [31:0] r;

    // reset state (R11: released pads read 1)
    wq(2);
    check("R11 reset sda_drive_n", sda_drive_n, 1);
    check("R11 reset scl_drive_n", scl_drive_n, 1);
    check("R5 reset irq", irq, 0);
    check("R4 reset buf_full", buf_full, 0);
    check("R8 reset ovf", ovf, 0);

    // directed write with stretching, local side driven by hand
    auto_sw = 0; stretch_en = 1; own_addr = 7'h2A;
    mstart();
    wbyte({7'h2A, 1'b0}, ack);
    check("R3 address ack", ack, 0);
    check("R3 rw write", rw, 0);
    check("R5 irq after address", irq, 1);
    check("R6 scl held", scl_drive_n, 0);
    rq_rel++; wq(5);
    check("R6 scl freed after release", scl_drive_n, 1);
    check("R5 irq cleared", irq, 0);
    wbyte(8'hA5, ack);
    check("R4 data ack", ack, 0);
    check("R4 buf_full set", buf_full, 1);
    check("R7 data MSB first", rx_data, 8'hA5);
    rq_rel++; wq(5);
    wbyte(8'h3C, ack);
    check("R4 nack while full", ack, 1);
    check("R8 ovf set", ovf, 1);
    check("R4 rx unchanged", rx_data, 8'hA5);
    rq_rel++; rq_rd++; wq(5);
    check("R8 rd clears full", buf_full, 0);
    check("R8 ovf sticky", ovf, 1);
    wbyte(8'h11, ack);
    check("R8 nack while ovf pending", ack, 1);
    check("R4 rx unchanged by ovf nack", rx_data, 8'hA5);
    rq_rel++; rq_oclr++; wq(5);
    check("R8 ovf_clr clears", ovf, 0);
    wbyte(8'h96, ack);
    check("R4 ack after clear", ack, 0);
    check("R7 rx second", rx_data, 8'h96);
    rq_rel++; rq_rd++; wq(5);
    mstop(); wq(4);
    check("R1 stop releases sda", sda_drive_n, 1);
    check("R1 stop releases scl", scl_drive_n, 1);

    // no stretching on a received byte
    stretch_en = 0;
    mstart();
    wbyte({7'h2A, 1'b0}, ack);
    check("R6 no hold in receive", scl_drive_n, 1);
    rq_rel++; wq(4);
    wbyte(8'h42, ack);
    check("R6 no hold after data", scl_drive_n, 1);
    check("R5 irq without stretch", irq, 1);
    check("R4 rx 42", rx_data, 8'h42);
    rq_rel++; rq_rd++; wq(4);
    mstop();

    // address mismatch
    auto_sw = 1; stretch_en = 1;
    g0 = gn;
    mstart();
    wbyte({7'h15, 1'b0}, ack);
    check("R2 mismatch nack", ack, 1);
    check("R2 mismatch no irq", irq, 0);
    wbyte(8'h00, ack);
    check("R2 following byte ignored", ack, 1);
    check("R2 nothing received", gn - g0, 0);
    mstop();

    // read transfer, master NACKs last byte
    txq[tn] = 8'hC3; txq[tn + 1] = 8'h5A; txq[tn + 2] = 8'h81;
    t0 = tn;
    mstart();
    wbyte({7'h2A, 1'b1}, ack);
    check("R3 read address ack", ack, 0);
    check("R3 rw read", rw, 1);
    rbyte(d, 1'b0);
    check("R9 first sent byte", d, 8'hC3);
    rbyte(d, 1'b0);
    check("R7 second sent byte", d, 8'h5A);
    rbyte(d, 1'b1);
    check("R9 third sent byte", d, 8'h81);
    check("R10 sda released after nack", sda_drive_n, 1);
    rbyte(d, 1'b1);
    check("R10 idle after nack", d, 8'hFF);
    check("R10 no load after nack", tn - t0, 3);
    mstop();

    // repeated start turns a write into a read
    txq[tn] = 8'h6E;
    g0 = gn;
    mstart();
    wbyte({7'h2A, 1'b0}, ack);
    wbyte(8'h7E, ack);
    check("R4 byte before rstart", got[g0], 8'h7E);
    mstart();
    wbyte({7'h2A, 1'b1}, ack);
    check("R1 rstart address ack", ack, 0);
    rbyte(d, 1'b1);
    check("R1 read after rstart", d, 8'h6E);
    mstop();

    // constrained random writes
    r = $urandom(32'h5EED);
    for (int t = 0; t < 16; t++) begin
      logic [6:0] a;
      int nb;
      logic [7:0] bytes [3];
      own_addr = 7'($urandom_range(8, 119));
      stretch_en = 1'($urandom_range(0, 1));
      a = ($urandom_range(0, 9) < 7) ? own_addr : (own_addr ^ 7'($urandom_range(1, 127)));
      nb = $urandom_range(1, 3);
      g0 = gn;
      mstart();
      wbyte({a, 1'b0}, ack);
      check("R2 random address ack", ack, exp_ack(a, own_addr));
      for (int j = 0; j < nb; j++) begin
        bytes[j] = 8'($urandom);
        wbyte(bytes[j], ack);
        check("R4 random data ack", ack, exp_ack(a, own_addr));
        if (a == own_addr) check("R7 random data value", got[g0 + j], bytes[j]);
      end
      check("R2 random byte count", gn - g0, (a == own_addr) ? nb : 0);
      mstop();
    end
  endtask

  initial begin
    logic wd;
    wd = 0;
    auto_sw = 0; m_scl = 1; m_sda = 1;
    own_addr = 7'h2A; stretch_en = 1;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    fork
      run_all();
      begin repeat (190000) @(posedge clk); wd = 1; end
    join_any
    if (wd) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule